// File: doc/BRIEF.md
# Tag-Store-With-Zeroing Execution Unit

This unit carries out one memory-tagging store instruction. A valid/ready handshake hands it a 32-bit instruction word. The unit checks the encoding and reads the base register and the tag-source register through two read ports. Index 31 on either read means the stack pointer instead. The unit then forms the target address in one of three addressing forms and checks it for 16-byte alignment. On success it issues two requests on a one-at-a-time memory port: a write of sixteen zero bytes, then a write of the 4-bit allocation tag for that granule. It finally writes the updated base back to the register file or the stack pointer when the form asks for it.

Each operation ends with a one-cycle completion pulse carrying a status code: 0 success, 1 undefined instruction, 2 stack-pointer misalignment, 3 granule misalignment. The controller has these states: IDLE (accept), DECODE (check encoding, latch operands), ADDR (alignment checks), DATA_WR (zero-data request), TAG_WR (tag request), WRBACK (base update) and DONE (status pulse). It moves through them as follows:
- IDLE→DECODE on accept.
- DECODE→DONE on an illegal word, otherwise DECODE→ADDR.
- ADDR→DONE on a fault, otherwise ADDR→DATA_WR.
- DATA_WR→TAG_WR when the memory port takes the request.
- TAG_WR→WRBACK, or TAG_WR→DONE when the form has no writeback.
- WRBACK→DONE.
- DONE→IDLE.

Top module: `tagzero_store_unit`

## Requirements
- R1: When the enable input is low, or bits [31:21] of the word differ from 11011001011 (binary), the unit completes with status 1 and makes no memory request, register write or stack-pointer write.
- R2: Fields: imm9 = bits [20:12], mode = bits [11:10], base index = bits [9:5], source index = bits [4:0]. A mode of 00 is undefined and completes with status 1 with no side effects.
- R3: The offset is imm9 sign-extended and multiplied by 16, so it spans -4096 to 4080.
- R4: Mode 11 (pre-index) accesses base+offset and writes base+offset back to the base register.
- R5: Mode 01 (post-index) accesses the unmodified base and writes base+offset back to the base register.
- R6: Mode 10 (signed offset) accesses base+offset and performs no writeback.
- R7: Base index 31 selects the stack pointer as base, and its writeback goes to the stack pointer and not the register file. If the stack pointer has any of bits [3:0] set, the unit completes with status 2 and has no side effects.
- R8: If the access address has any of bits [3:0] set, the unit completes with status 3 and has no side effects.
- R9: On success the unit first issues a data request (tag flag 0) of 128 zero bits, then a tag request (tag flag 1) to the same address. The tag is bits [59:56] of the source value, and source index 31 reads the stack pointer.
- R10: Only one memory request is presented at a time. A request is held with unchanged address and kind until it is taken.
- R11: The request-ready output is high only in IDLE. The completion pulse lasts one cycle and reports status 0 on success.
- R12: After reset, request-ready is high and no memory request, register write, stack-pointer write or completion is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Tagging feature enable, sampled when a request is accepted |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle, instruction accepted on valid |
| req_insn | input | 32 | Instruction word |
| rf_rd_base_idx | output | 5 | Base register read index |
| rf_rd_base_data | input | 64 | Base register read data (same cycle) |
| rf_rd_src_idx | output | 5 | Tag-source register read index |
| rf_rd_src_data | input | 64 | Tag-source register read data (same cycle) |
| sp_value | input | 64 | Current stack pointer |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_data | output | 64 | Stack pointer write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_is_tag | output | 1 | 0 data write, 1 tag write |
| mem_req_addr | output | 64 | Granule address |
| mem_req_wdata | output | 128 | Data for a data write (zeros) |
| mem_req_tag | output | 4 | Tag for a tag write |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | Completion status code |

## Verification
The assertions assume the following about the environment:
- The register-file read data reflects the read indices in the same cycle.
- The memory port eventually raises ready.
- The stack-pointer input changes only through the unit's own writeback while an operation is in flight.

The bench keeps to these assumptions. It serves reads combinationally from a register model and updates that model and the stack pointer only on the unit's write strobes. It changes the enable and register contents only while the unit is idle. In its stall test it toggles memory ready every cycle, so each request is held at least once and is always taken soon after.

// File: rtl/tzs_pkg.sv
package tzs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ADDR,
        ST_DATA_WR,
        ST_TAG_WR,
        ST_WRBACK,
        ST_DONE
    } tzs_state_e;

    typedef enum logic [1:0] {
        STAT_OK        = 2'd0,
        STAT_UNDEF     = 2'd1,
        STAT_SP_ALIGN  = 2'd2,
        STAT_GRAN_ALIGN = 2'd3
    } tzs_status_e;

    typedef enum logic [1:0] {
        MODE_RSVD   = 2'b00,
        MODE_POST   = 2'b01,
        MODE_OFFSET = 2'b10,
        MODE_PRE    = 2'b11
    } tzs_mode_e;

    localparam int unsigned OPC_HI_W = 11;
    localparam logic [OPC_HI_W-1:0] OPC_HI_VALUE = 11'b11011001011;

endpackage

// File: rtl/tzs_decoder.sv
module tzs_decoder
    import tzs_pkg::*;
#(
    parameter int unsigned XLEN        = 64,
    parameter int unsigned IMM_W       = 9,
    parameter int unsigned GRAN_LOG2   = 4,
    parameter int unsigned IDX_W       = 5
) (
    input  logic [31:0]       insn,
    input  logic              feat_en,
    output logic              legal,
    output logic              do_wb,
    output logic              is_post,
    output logic [IDX_W-1:0]  base_idx,
    output logic [IDX_W-1:0]  src_idx,
    output logic [XLEN-1:0]   offset
);
    localparam int unsigned EXT_W   = XLEN - IMM_W - GRAN_LOG2;
    localparam int unsigned IMM_LSB = 12;
    localparam int unsigned MODE_LSB = 10;

    logic [IMM_W-1:0] imm;
    tzs_mode_e        mode;
    logic             hi_ok;

    always_comb begin
        imm      = insn[IMM_LSB +: IMM_W];
        mode     = tzs_mode_e'(insn[MODE_LSB +: 2]);
        base_idx = insn[5 +: IDX_W];
        src_idx  = insn[0 +: IDX_W];
        hi_ok    = (insn[31 -: OPC_HI_W] == OPC_HI_VALUE);
        legal    = feat_en && hi_ok && (mode != MODE_RSVD);
        do_wb    = (mode == MODE_POST) || (mode == MODE_PRE);
        is_post  = (mode == MODE_POST);
        offset   = {{EXT_W{imm[IMM_W-1]}}, imm, {GRAN_LOG2{1'b0}}};
    end

endmodule

// File: rtl/tzs_addr_gen.sv
module tzs_addr_gen #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned GRAN_LOG2 = 4
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic            is_post,
    output logic [XLEN-1:0] access_addr,
    output logic [XLEN-1:0] updated_addr,
    output logic            base_misaligned,
    output logic            access_misaligned
);
    logic [XLEN-1:0] sum;

    always_comb begin
        sum               = base + offset;
        access_addr       = is_post ? base : sum;
        updated_addr      = sum;
        base_misaligned   = |base[GRAN_LOG2-1:0];
        access_misaligned = |access_addr[GRAN_LOG2-1:0];
    end

endmodule

// File: rtl/tagzero_store_unit.sv
module tagzero_store_unit
    import tzs_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned IMM_W     = 9,
    parameter int unsigned GRAN_LOG2 = 4,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned TAG_W     = 4,
    parameter int unsigned TAG_LSB   = 56
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     feat_en,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [31:0]              req_insn,
    output logic [IDX_W-1:0]         rf_rd_base_idx,
    input  logic [XLEN-1:0]          rf_rd_base_data,
    output logic [IDX_W-1:0]         rf_rd_src_idx,
    input  logic [XLEN-1:0]          rf_rd_src_data,
    input  logic [XLEN-1:0]          sp_value,
    output logic                     rf_wr_en,
    output logic [IDX_W-1:0]         rf_wr_idx,
    output logic [XLEN-1:0]          rf_wr_data,
    output logic                     sp_wr_en,
    output logic [XLEN-1:0]          sp_wr_data,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic                     mem_req_is_tag,
    output logic [XLEN-1:0]          mem_req_addr,
    output logic [(8<<GRAN_LOG2)-1:0] mem_req_wdata,
    output logic [TAG_W-1:0]         mem_req_tag,
    output logic                     done_valid,
    output logic [1:0]               done_status
);
    localparam int unsigned GRAN_BITS = 8 << GRAN_LOG2;
    localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};

    tzs_state_e  state_q, state_d;
    tzs_status_e status_q, status_d;
    logic [31:0]      insn_q;
    logic             feat_q;
    logic [XLEN-1:0]  base_q, src_q;

    logic             dec_legal, dec_wb, dec_post;
    logic [IDX_W-1:0] dec_base_idx, dec_src_idx;
    logic [XLEN-1:0]  dec_offset;

    logic [XLEN-1:0]  acc_addr, upd_addr;
    logic             base_mis, acc_mis;
    logic             base_is_sp, src_is_sp;
    logic [XLEN-1:0]  base_sel, src_sel;

    tzs_decoder #(
        .XLEN(XLEN), .IMM_W(IMM_W), .GRAN_LOG2(GRAN_LOG2), .IDX_W(IDX_W)
    ) u_dec (
        .insn     (insn_q),
        .feat_en  (feat_q),
        .legal    (dec_legal),
        .do_wb    (dec_wb),
        .is_post  (dec_post),
        .base_idx (dec_base_idx),
        .src_idx  (dec_src_idx),
        .offset   (dec_offset)
    );

    tzs_addr_gen #(
        .XLEN(XLEN), .GRAN_LOG2(GRAN_LOG2)
    ) u_agen (
        .base              (base_q),
        .offset            (dec_offset),
        .is_post           (dec_post),
        .access_addr       (acc_addr),
        .updated_addr      (upd_addr),
        .base_misaligned   (base_mis),
        .access_misaligned (acc_mis)
    );

    // Register index 31 reads the stack pointer on either operand.
    always_comb begin
        base_is_sp = (dec_base_idx == SP_IDX);
        src_is_sp  = (dec_src_idx == SP_IDX);
        base_sel   = base_is_sp ? sp_value : rf_rd_base_data;
        src_sel    = src_is_sp  ? sp_value : rf_rd_src_data;
    end

    // State and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= STAT_OK;
            insn_q   <= '0;
            feat_q   <= 1'b0;
            base_q   <= '0;
            src_q    <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            if (state_q == ST_IDLE && req_valid) begin
                insn_q <= req_insn;
                feat_q <= feat_en;
            end
            if (state_q == ST_DECODE) begin
                base_q <= base_sel;
                src_q  <= src_sel;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d  = ST_DECODE;
                    status_d = STAT_OK;
                end
            end
            ST_DECODE: begin
                if (!dec_legal) begin
                    state_d  = ST_DONE;
                    status_d = STAT_UNDEF;
                end else begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (base_is_sp && base_mis) begin
                    state_d  = ST_DONE;
                    status_d = STAT_SP_ALIGN;
                end else if (acc_mis) begin
                    state_d  = ST_DONE;
                    status_d = STAT_GRAN_ALIGN;
                end else begin
                    state_d = ST_DATA_WR;
                end
            end
            ST_DATA_WR: begin
                if (mem_req_ready) state_d = ST_TAG_WR;
            end
            ST_TAG_WR: begin
                if (mem_req_ready) state_d = dec_wb ? ST_WRBACK : ST_DONE;
            end
            ST_WRBACK: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready      = 1'b0;
        rf_rd_base_idx = dec_base_idx;
        rf_rd_src_idx  = dec_src_idx;
        rf_wr_en       = 1'b0;
        rf_wr_idx      = dec_base_idx;
        rf_wr_data     = upd_addr;
        sp_wr_en       = 1'b0;
        sp_wr_data     = upd_addr;
        mem_req_valid  = 1'b0;
        mem_req_is_tag = 1'b0;
        mem_req_addr   = acc_addr;
        mem_req_wdata  = {GRAN_BITS{1'b0}};
        mem_req_tag    = src_q[TAG_LSB +: TAG_W];
        done_valid     = 1'b0;
        done_status    = status_q;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_DECODE:  ;
            ST_ADDR:    ;
            ST_DATA_WR: mem_req_valid = 1'b1;
            ST_TAG_WR: begin
                mem_req_valid  = 1'b1;
                mem_req_is_tag = 1'b1;
            end
            ST_WRBACK: begin
                sp_wr_en = base_is_sp;
                rf_wr_en = !base_is_sp;
            end
            ST_DONE:    done_valid = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/tzs_checker.sv
module tzs_checker #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned GRAN_LOG2 = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_ready,
    input logic                      mem_req_valid,
    input logic                      mem_req_ready,
    input logic                      mem_req_is_tag,
    input logic [XLEN-1:0]           mem_req_addr,
    input logic [(8<<GRAN_LOG2)-1:0] mem_req_wdata,
    input logic                      rf_wr_en,
    input logic                      sp_wr_en,
    input logic                      done_valid
);
    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_is_tag)));

    assert_tag_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_is_tag) |=>
        (mem_req_valid && mem_req_is_tag && mem_req_addr == $past(mem_req_addr)));

    assert_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_is_tag) |-> (mem_req_wdata == '0));

    assert_aligned_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[GRAN_LOG2-1:0] == '0));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !done_valid));

    assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_wr_en, sp_wr_en, mem_req_valid}));

endmodule

bind tagzero_store_unit tzs_checker #(.XLEN(XLEN), .GRAN_LOG2(GRAN_LOG2)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_is_tag (mem_req_is_tag),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .rf_wr_en       (rf_wr_en),
    .sp_wr_en       (sp_wr_en),
    .done_valid     (done_valid)
);

// File: tb/tagzero_store_unit_tb_top.sv
module tagzero_store_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         feat_en = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_insn = '0;
    logic [4:0]   rf_rd_base_idx, rf_rd_src_idx;
    logic [63:0]  rf_rd_base_data, rf_rd_src_data;
    logic [63:0]  sp_value;
    logic         rf_wr_en, sp_wr_en;
    logic [4:0]   rf_wr_idx;
    logic [63:0]  rf_wr_data, sp_wr_data;
    logic         mem_req_valid, mem_req_ready, mem_req_is_tag;
    logic [63:0]  mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic [3:0]   mem_req_tag;
    logic         done_valid;
    logic [1:0]   done_status;

    always #5 clk = ~clk;

    tagzero_store_unit dut_i (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_insn(req_insn),
        .rf_rd_base_idx(rf_rd_base_idx), .rf_rd_base_data(rf_rd_base_data),
        .rf_rd_src_idx(rf_rd_src_idx), .rf_rd_src_data(rf_rd_src_data),
        .sp_value(sp_value),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_is_tag(mem_req_is_tag), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_tag(mem_req_tag),
        .done_valid(done_valid), .done_status(done_status)
    );

    // Register and stack-pointer model
    logic [63:0] xreg [0:31];
    logic [63:0] sp_q;
    assign sp_value        = sp_q;
    assign rf_rd_base_data = xreg[rf_rd_base_idx];
    assign rf_rd_src_data  = xreg[rf_rd_src_idx];

    // Observation
    int          n_data, n_tag, n_rfw, n_spw, order_err;
    logic [63:0] data_addr, tag_addr;
    logic [127:0] data_val;
    logic [3:0]  tag_val;
    logic        stall_en = 1'b0;
    int          pass_cnt = 0, fail_cnt = 0;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_valid && mem_req_ready) begin
            if (!mem_req_is_tag) begin
                n_data++; data_addr = mem_req_addr; data_val = mem_req_wdata;
            end else begin
                if (n_data == 0) order_err++;
                n_tag++; tag_addr = mem_req_addr; tag_val = mem_req_tag;
            end
        end
        if (rf_wr_en) begin xreg[rf_wr_idx] = rf_wr_data; n_rfw++; end
        if (sp_wr_en) begin sp_q = sp_wr_data; n_spw++; end
    end

    always @(negedge clk) begin
        if (!rst_n) mem_req_ready <= 1'b1;
        else        mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fail_cnt++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected under 100000)", cyc);
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] mode, input logic [8:0] imm,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return {11'b11011001011, imm, mode, rn, rt};
    endfunction

    logic [1:0] last_status;

    task automatic run_op(input logic [31:0] insn);
        int guard;
        n_data = 0; n_tag = 0; n_rfw = 0; n_spw = 0; order_err = 0;
        @(negedge clk);
        req_valid = 1'b1; req_insn = insn;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done_valid && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 1000, "R11 completion seen", 128'(guard), 128'd0);
        last_status = done_status;
        @(negedge clk);
    endtask

    task automatic expect_no_effect(input string req, input logic [1:0] exp_stat);
        check(last_status == exp_stat, req, 128'(last_status), 128'(exp_stat));
        check(n_data == 0 && n_tag == 0, req, 128'(n_data + n_tag), 128'd0);
        check(n_rfw == 0 && n_spw == 0, req, 128'(n_rfw + n_spw), 128'd0);
    endtask

    task automatic expect_store(input string req, input logic [63:0] addr, input logic [3:0] tag);
        check(last_status == 2'd0, req, 128'(last_status), 128'd0);
        check(n_data == 1 && n_tag == 1 && order_err == 0, req,
              128'(n_data * 16 + n_tag), 128'h11);
        check(data_addr == addr && tag_addr == addr, req, 128'(data_addr), 128'(addr));
        check(data_val == '0, "R9 zero data", data_val, 128'd0);
        check(tag_val == tag, "R9 tag bits 59:56", 128'(tag_val), 128'(tag));
    endtask

    task automatic t_reset_R12();
        check(req_ready == 1'b1, "R12 ready", 128'(req_ready), 128'd1);
        check(!mem_req_valid && !done_valid && !rf_wr_en && !sp_wr_en, "R12 idle outputs",
              128'({mem_req_valid, done_valid, rf_wr_en, sp_wr_en}), 128'd0);
    endtask

    task automatic t_pre_R4();
        xreg[2] = 64'h1000; xreg[5] = 64'h0A00_0000_0000_0000;
        run_op(mk(2'b11, 9'd3, 5'd2, 5'd5));
        expect_store("R4 pre-index", 64'h1030, 4'hA);
        check(xreg[2] == 64'h1030 && n_rfw == 1 && n_spw == 0, "R4 writeback", 128'(xreg[2]), 128'h1030);
    endtask

    task automatic t_post_R5();
        xreg[3] = 64'h2000; xreg[6] = 64'h0300_0000_0000_0000;
        run_op(mk(2'b01, 9'h1FE, 5'd3, 5'd6));
        expect_store("R5 post-index", 64'h2000, 4'h3);
        check(xreg[3] == 64'h1FE0, "R5 R3 negative writeback", 128'(xreg[3]), 128'h1FE0);
    endtask

    task automatic t_offset_R6();
        xreg[4] = 64'h3000; xreg[8] = 64'h0500_0000_0000_0000;
        run_op(mk(2'b10, 9'h0FF, 5'd4, 5'd8));
        expect_store("R6 R3 max offset", 64'h3FF0, 4'h5);
        check(n_rfw == 0 && n_spw == 0 && xreg[4] == 64'h3000, "R6 no writeback", 128'(xreg[4]), 128'h3000);
        xreg[4] = 64'h5000;
        run_op(mk(2'b10, 9'h100, 5'd4, 5'd8));
        expect_store("R3 min offset", 64'h4000, 4'h5);
    endtask

    task automatic t_sp_base_R7();
        sp_q = 64'h8000; xreg[9] = 64'h0700_0000_0000_0000; xreg[31] = 64'hDEAD_0000;
        run_op(mk(2'b11, 9'd1, 5'd31, 5'd9));
        expect_store("R7 stack base", 64'h8010, 4'h7);
        check(sp_q == 64'h8010 && n_spw == 1 && n_rfw == 0, "R7 writeback to SP", 128'(sp_q), 128'h8010);
    endtask

    task automatic t_sp_src_R9();
        sp_q = 64'h0F00_0000_0000_8000; xreg[10] = 64'h6000;
        run_op(mk(2'b10, 9'd0, 5'd10, 5'd31));
        expect_store("R9 SP as tag source", 64'h6000, 4'hF);
    endtask

    task automatic t_faults_R7_R8();
        sp_q = 64'h8008;
        run_op(mk(2'b11, 9'd1, 5'd31, 5'd9));
        expect_no_effect("R7 SP misaligned", 2'd2);
        check(sp_q == 64'h8008, "R7 SP unchanged", 128'(sp_q), 128'h8008);
        xreg[7] = 64'h1004;
        run_op(mk(2'b11, 9'd2, 5'd7, 5'd9));
        expect_no_effect("R8 granule misaligned", 2'd3);
        check(xreg[7] == 64'h1004, "R8 base unchanged", 128'(xreg[7]), 128'h1004);
    endtask

    task automatic t_undef_R1_R2();
        xreg[2] = 64'h1000;
        run_op(mk(2'b11, 9'd1, 5'd2, 5'd5) ^ 32'h0040_0000);
        expect_no_effect("R1 bad opcode bits", 2'd1);
        run_op(mk(2'b00, 9'd1, 5'd2, 5'd5));
        expect_no_effect("R2 mode 00 undefined", 2'd1);
        feat_en = 1'b0;
        run_op(mk(2'b11, 9'd1, 5'd2, 5'd5));
        feat_en = 1'b1;
        expect_no_effect("R1 feature disabled", 2'd1);
        check(xreg[2] == 64'h1000, "R1 base unchanged", 128'(xreg[2]), 128'h1000);
    endtask

    task automatic t_stall_R10();
        stall_en = 1'b1;
        xreg[11] = 64'h7000; xreg[12] = 64'h0C00_0000_0000_0000;
        run_op(mk(2'b11, 9'h1FF, 5'd11, 5'd12));
        stall_en = 1'b0;
        expect_store("R10 stalled port", 64'h6FF0, 4'hC);
        check(xreg[11] == 64'h6FF0, "R10 writeback", 128'(xreg[11]), 128'h6FF0);
    endtask

    task automatic t_pulse_R11();
        xreg[2] = 64'h1000;
        run_op(mk(2'b10, 9'd0, 5'd2, 5'd5));
        check(!done_valid && req_ready, "R11 pulse one cycle then idle",
              128'({done_valid, req_ready}), 128'b01);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) xreg[i] = '0;
        sp_q = '0;
        n_data = 0; n_tag = 0; n_rfw = 0; n_spw = 0; order_err = 0;
        repeat (3) @(negedge clk);
        t_reset_R12();
        rst_n = 1'b1;
        @(negedge clk);
        t_pre_R4();
        t_post_R5();
        t_offset_R6();
        t_sp_base_R7();
        t_sp_src_R9();
        t_faults_R7_R8();
        t_undef_R1_R2();
        t_stall_R10();
        t_pulse_R11();
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

endmodule